// File: doc/BRIEF.md
# Bus clock prescaler generator

This block produces two clock-enable strobes from the system clock: one for a fast on-chip bus and one for a slower peripheral bus. The fast-bus strobe rate is selected by a 4-bit divide code. The slow-bus strobe is not taken from the system clock directly: it is a further division of the fast-bus strobe, selected by a 3-bit code. Logic on either bus advances only in system cycles in which its strobe is high, so no gated clock cells are needed.

The block also gates a set of per-peripheral enable bits on each bus. When software sets an enable bit, the matching ready output rises only after two strobes of that peripheral's own bus have been counted. Register accesses issued before ready is high would otherwise reach a peripheral whose clock has not yet started. A new divide code is never applied in the middle of a divided period. It is taken up at the end of the period already running, so no strobe ever arrives early.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high, `fast_tick`, `slow_tick` and every ready output are 0. After reset, with both codes at 0, both strobes are high in every system cycle.
- R2: A fast code with bit 3 clear (values 0 to 7) gives no division: `fast_tick` is high in every system cycle.
- R3: Fast codes 8 to 15 divide the system clock by 2, 4, 8, 16, 64, 128, 256 and 512 respectively (divide-by-32 is not available). `fast_tick` is then high for exactly one system cycle per period.
- R4: A slow code with bit 2 clear (values 0 to 3) gives no further division: `slow_tick` is high in exactly the cycles in which `fast_tick` is high.
- R5: Slow codes 4 to 7 give one `slow_tick` per 2, 4, 8 and 16 fast strobes respectively. `slow_tick` is only ever high in a cycle in which `fast_tick` is high.
- R6: A code change is taken up at the end of the divided period that is in progress. That period completes at the old ratio, and the following period uses the new ratio.
- R7: A ready output rises in the cycle after the second strobe of its own bus (fast for `fast_ready`, slow for `slow_ready`) that is counted while its enable bit is high. A strobe that is present in the same cycle the enable bit is first seen counts. Ready stays high while the enable stays high.
- R8: Clearing an enable bit drops its ready output in the next cycle. Setting it again restarts the count of two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_code | input | 4 | Fast-bus divide code |
| slow_code | input | 3 | Slow-bus divide code, applied on top of the fast-bus rate |
| fast_en | input | N_FAST | Enable bits of the fast-bus peripherals |
| slow_en | input | N_SLOW | Enable bits of the slow-bus peripherals |
| fast_tick | output | 1 | Fast-bus clock-enable strobe |
| slow_tick | output | 1 | Slow-bus clock-enable strobe |
| fast_ready | output | N_FAST | Per-peripheral ready on the fast bus |
| slow_ready | output | N_SLOW | Per-peripheral ready on the slow bus |

## Verification
A wrong period counter or a wrongly latched shift shows up as a strobe interval that differs from the code table, within one divided period of the fault. The bench measures the intervals for every code on both buses. A divide code latched at the wrong moment shows up as a shortened or stretched interval right after the code changes, so the first two intervals after a change are compared with the old and the new ratio. A fault in a ready counter shows up as ready rising one strobe early or late, or failing to fall in the cycle after its enable bit clears. The bench follows this cycle by cycle against the strobes it observes.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  localparam int FAST_CODE_W = 4;
  localparam int SLOW_CODE_W = 3;
  localparam int SHIFT_W     = 4;
  localparam int FAST_MAX_SH = 9;
  localparam int SLOW_MAX_SH = 4;

  // Fast code: bit 3 clear -> no division; else 2^(idx+1), skipping 2^5.
  function automatic logic [SHIFT_W-1:0] fast_shift(input logic [FAST_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] idx;
    idx = {1'b0, code[2:0]};
    if (!code[3]) return '0;
    return (idx >= 4'd4) ? idx + 4'd2 : idx + 4'd1;
  endfunction

  // Slow code: bit 2 clear -> no division; else 2^(idx+1).
  function automatic logic [SHIFT_W-1:0] slow_shift(input logic [SLOW_CODE_W-1:0] code);
    if (!code[2]) return '0;
    return {2'b00, code[1:0]} + 4'd1;
  endfunction

endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int SHIFT_W = 4,
  parameter int MAX_SH  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [SHIFT_W-1:0] shift_in,
  output logic               tick_nxt,
  output logic               tick
);
  localparam int CNT_W = (MAX_SH < 1) ? 1 : MAX_SH;

  logic [CNT_W-1:0]   cnt;
  logic [SHIFT_W-1:0] shift_r;
  logic [CNT_W-1:0]   last_cnt;

  // Highest count of the running period: 2^shift_r - 1.
  assign last_cnt = ~({CNT_W{1'b1}} << shift_r);
  assign tick_nxt = adv && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      shift_r <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= tick_nxt;
      if (tick_nxt) begin
        cnt     <= '0;
        shift_r <= shift_in;
      end else if (adv) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ready_gate.sv
module ready_gate #(
  parameter int N     = 4,
  parameter int DELAY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_tick,
  input  logic [N-1:0] en,
  output logic [N-1:0] ready
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
      if (!en[g])                          cnt_nxt = '0;
      else if (bus_tick && (cnt != FULL))  cnt_nxt = cnt + 1'b1;
      else                                 cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt      <= '0;
        ready[g] <= 1'b0;
      end else begin
        cnt      <= cnt_nxt;
        ready[g] <= en[g] && (cnt_nxt == FULL);
      end
    end
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int N_FAST      = 4,
  parameter int N_SLOW      = 4,
  parameter int READY_DELAY = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FAST_CODE_W-1:0] fast_code,
  input  logic [SLOW_CODE_W-1:0] slow_code,
  input  logic [N_FAST-1:0]      fast_en,
  input  logic [N_SLOW-1:0]      slow_en,
  output logic                   fast_tick,
  output logic                   slow_tick,
  output logic [N_FAST-1:0]      fast_ready,
  output logic [N_SLOW-1:0]      slow_ready
);
  logic fast_nxt, slow_nxt;

  strobe_div #(.SHIFT_W(SHIFT_W), .MAX_SH(FAST_MAX_SH)) u_fast_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (1'b1),
    .shift_in (fast_shift(fast_code)),
    .tick_nxt (fast_nxt),
    .tick     (fast_tick)
  );

  // Slow divider advances on the fast strobe so both registered strobes align.
  strobe_div #(.SHIFT_W(SHIFT_W), .MAX_SH(SLOW_MAX_SH)) u_slow_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (fast_nxt),
    .shift_in (slow_shift(slow_code)),
    .tick_nxt (slow_nxt),
    .tick     (slow_tick)
  );

  ready_gate #(.N(N_FAST), .DELAY(READY_DELAY)) u_fast_gate (
    .clk      (clk),
    .rst      (rst),
    .bus_tick (fast_tick),
    .en       (fast_en),
    .ready    (fast_ready)
  );

  ready_gate #(.N(N_SLOW), .DELAY(READY_DELAY)) u_slow_gate (
    .clk      (clk),
    .rst      (rst),
    .bus_tick (slow_tick),
    .en       (slow_en),
    .ready    (slow_ready)
  );
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int N_FAST = 4,
  parameter int N_SLOW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fast_tick,
  input logic              slow_tick,
  input logic [N_FAST-1:0] fast_en,
  input logic [N_SLOW-1:0] slow_en,
  input logic [N_FAST-1:0] fast_ready,
  input logic [N_SLOW-1:0] slow_ready
);
  // R5: slow strobe only inside a fast strobe
  p_slow_in_fast_r5: assert property (@(posedge clk) disable iff (rst)
    slow_tick |-> fast_tick);

  // R8: ready never high unless its enable was seen at the previous edge
  p_fast_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (fast_ready & ~$past(fast_en)) == '0);
  p_slow_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (slow_ready & ~$past(slow_en)) == '0);

  // R7: a ready bit only rises after an edge that saw its bus strobe
  p_fast_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((fast_ready & ~$past(fast_ready)) != '0) |-> $past(fast_tick));
  p_slow_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((slow_ready & ~$past(slow_ready)) != '0) |-> $past(slow_tick));

  // R7: ready holds while its enable holds
  p_fast_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(fast_ready) & $past(fast_en) & ~fast_ready) == '0);
  p_slow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(slow_ready) & $past(slow_en) & ~slow_ready) == '0);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.N_FAST(N_FAST), .N_SLOW(N_SLOW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fast_tick  (fast_tick),
  .slow_tick  (slow_tick),
  .fast_en    (fast_en),
  .slow_en    (slow_en),
  .fast_ready (fast_ready),
  .slow_ready (slow_ready)
);

// File: tb/bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb;
  localparam int NF = 4;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    fast_code = '0;
  logic [2:0]    slow_code = '0;
  logic [NF-1:0] fast_en = '0;
  logic [NS-1:0] slow_en = '0;
  logic          fast_tick, slow_tick;
  logic [NF-1:0] fast_ready;
  logic [NS-1:0] slow_ready;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  bus_strobe_gen #(.N_FAST(NF), .N_SLOW(NS)) u_dut (
    .clk(clk), .rst(rst), .fast_code(fast_code), .slow_code(slow_code),
    .fast_en(fast_en), .slow_en(slow_en), .fast_tick(fast_tick),
    .slow_tick(slow_tick), .fast_ready(fast_ready), .slow_ready(slow_ready)
  );

  function automatic int f_fast_ratio(input logic [3:0] c);
    int tbl [8] = '{2, 4, 8, 16, 64, 128, 256, 512};
    return c[3] ? tbl[c[2:0]] : 1;
  endfunction

  function automatic int f_slow_ratio(input logic [2:0] c);
    return c[2] ? (2 << c[1:0]) : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit slow);
    do @(negedge clk); while (!(slow ? slow_tick : fast_tick));
  endtask

  // Cycles from the current strobe to the next one; also watches R5 nesting.
  task automatic interval(input bit slow, output int n, output bit nest_ok);
    n = 0; nest_ok = 1;
    do begin
      @(negedge clk);
      n++;
      if (slow_tick && !fast_tick) nest_ok = 0;
    end while (!(slow ? slow_tick : fast_tick));
  endtask

  task automatic measure(input bit slow, input int exp, input string req);
    int n; bit nok;
    wait_tick(slow);
    interval(slow, n, nok);   // may straddle the code change
    interval(slow, n, nok);   // may still be the first new period
    interval(slow, n, nok);
    chk(n == exp, req, n, exp);
    if (slow) chk(nok, "R5 nesting", 0, 1);
  endtask

  // Enable one peripheral, follow ready cycle by cycle, then clear it.
  task automatic ready_trial(input bit slow, input int idx);
    int seen; bit ok; int bad_v;
    ok = 1; bad_v = 0;
    if (slow) slow_en[idx] = 1'b1; else fast_en[idx] = 1'b1;
    seen = (slow ? slow_tick : fast_tick) ? 1 : 0;
    for (int k = 0; k < 40000; k++) begin
      logic r;
      @(negedge clk);
      r = slow ? slow_ready[idx] : fast_ready[idx];
      if (r != (seen >= 2)) begin ok = 0; bad_v = r; end
      if (seen >= 2) break;
      if (slow ? slow_tick : fast_tick) seen++;
    end
    chk(ok && seen >= 2, slow ? "R7 slow ready timing" : "R7 fast ready timing", bad_v, seen >= 2);
    repeat (3) @(negedge clk);
    chk((slow ? slow_ready[idx] : fast_ready[idx]) == 1'b1, "R7 ready holds", 0, 1);
    if (slow) slow_en[idx] = 1'b0; else fast_en[idx] = 1'b0;
    @(negedge clk);
    chk((slow ? slow_ready[idx] : fast_ready[idx]) == 1'b0, "R8 ready drops next cycle", 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n; bit nok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!fast_tick && !slow_tick && fast_ready == '0 && slow_ready == '0,
        "R1 outputs low in reset", fast_tick + slow_tick, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(fast_tick && slow_tick, "R1 full rate after reset", fast_tick + slow_tick, 2);
    @(negedge clk);
    chk(fast_tick && slow_tick, "R1 full rate after reset", fast_tick + slow_tick, 2);

    // R2 / R3: every fast code
    for (int c = 0; c < 16; c++) begin
      fast_code = 4'(c);
      measure(1'b0, f_fast_ratio(4'(c)), c < 8 ? "R2 fast undivided" : "R3 fast ratio");
    end

    // R4 / R5: every slow code over a fast ratio of 4
    fast_code = 4'd9;
    for (int c = 0; c < 8; c++) begin
      slow_code = 3'(c);
      measure(1'b1, 4 * f_slow_ratio(3'(c)), c < 4 ? "R4 slow undivided" : "R5 slow ratio");
    end

    // R6: change from /8 to /2 in mid period
    slow_code = 3'd0;
    fast_code = 4'd10;
    measure(1'b0, 8, "R6 setup");
    wait_tick(1'b0);
    repeat (3) @(negedge clk);
    fast_code = 4'd8;
    interval(1'b0, n, nok);
    chk(n == 5, "R6 old ratio completes", n, 5);
    interval(1'b0, n, nok);
    chk(n == 2, "R6 new ratio after boundary", n, 2);
    // R6: slow side, /16 to /2 over fast /2
    slow_code = 3'd7;
    measure(1'b1, 32, "R6 slow setup");
    wait_tick(1'b1);
    repeat (5) @(negedge clk);
    slow_code = 3'd4;
    interval(1'b1, n, nok);
    chk(n == 27, "R6 slow old ratio completes", n, 27);
    interval(1'b1, n, nok);
    chk(n == 4, "R6 slow new ratio", n, 4);

    // R7 / R8 directed
    fast_code = 4'd0; slow_code = 3'd0;
    repeat (2) @(negedge clk);
    ready_trial(1'b0, 0);
    fast_code = 4'd11;
    repeat (3) @(negedge clk);
    ready_trial(1'b0, 2);
    slow_code = 3'd5;
    repeat (5) @(negedge clk);
    ready_trial(1'b1, 1);

    // Random trials
    for (int t = 0; t < 10; t++) begin
      logic [3:0] fc; logic [2:0] sc;
      fc = 4'($urandom_range(0, 13));
      sc = 3'($urandom_range(0, 7));
      fast_code = fc; slow_code = sc;
      measure(1'b0, f_fast_ratio(fc), "R3 random fast ratio");
      measure(1'b1, f_fast_ratio(fc) * f_slow_ratio(sc), "R5 random slow ratio");
      repeat ($urandom_range(0, 5)) @(negedge clk);
      ready_trial(t[0], $urandom_range(0, 3));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule